// File: doc/BRIEF.md
# Register-Driven SPI Master with Byte Queues

This block is a serial-peripheral master that software drives through a small word-addressed register file. Bytes to send are written into a transmit queue. Bytes that come back are collected in a receive queue. Software learns whether a queue is full or empty from bit 31 of the data registers themselves. Each frame is shifted out by an engine that produces the serial clock from the peripheral clock through a programmable divisor.

The frame format register selects several settings. It sets the idle clock level and the sampling edge. It sets the frame length, from 1 to 8 bits, and the bit order. It also picks one, two or four data lanes. With one lane the link is full duplex, so every frame sent also returns one received frame. With two or four lanes the link is half duplex, and a direction bit chooses between a transmit phase and a receive phase. A chip-select mode register decides how the select line behaves between frames: it can be released after every frame, held asserted, or kept off.

Register word addresses: 0 divisor, 1 frame format, 2 chip-select mode, 3 transmit data, 4 receive data. The frame format register holds these fields:
- bit 0: idle clock level (CPOL)
- bit 1: clock phase (CPHA)
- bits 3:2: lane code (0 one lane, 1 two lanes, 2 or 3 four lanes)
- bit 4: bit order (1 means least significant bit first)
- bit 5: multi-lane direction (1 transmit, 0 receive)
- bits 11:8: frame length (1 to 8; a value of 0 or above 8 means 8)

Chip-select mode codes: 0 per-frame, 1 hold, 2 or 3 off. Reset values: divisor 3, frame format 0x800, chip-select mode 0.

Top module: `spim_top`

## Requirements
- R1: A read of address 3 returns bit 31 set exactly while the transmit queue (8 entries) is full. A write to address 3 while the queue is full is discarded.
- R2: A read of address 4 returns 0x8000_0000 while the receive queue is empty. Otherwise it returns the oldest received byte in bits 7:0, with bit 31 clear, and removes that byte from the queue.
- R3: With one lane, every frame sent pushes exactly one received frame into the receive queue. MOSI is dq_out[0] and MISO is dq_in[1]. A frame does not start while the receive queue is full, so no received byte is lost.
- R4: With two or four lanes and direction set to transmit, each SCK period moves 2 or 4 bits. The earliest bit of each group is on the highest lane used. The lanes used have dq_oe set, and nothing enters the receive queue.
- R5: With two or four lanes and direction set to receive, dq_oe is 0 during the frame. The bits sampled on dq_in are assembled into one byte that is pushed into the receive queue.
- R6: In per-frame mode (code 0), cs_n is asserted for each frame and goes high again for at least one clock between frames.
- R7: In hold mode (code 1), cs_n stays low after a frame ends. When the mode changes away from hold, cs_n is released once the frame in flight, if any, has finished.
- R8: In off mode (code 2 or 3), cs_n stays high while frames are shifted.
- R9: Each SCK half period lasts divisor+1 peripheral clocks, counted from the start of the frame. While idle, SCK rests at the CPOL level.
- R10: With CPHA 0, data is sampled on the first (leading) SCK edge of each bit. With CPHA 1, data is driven on the leading edge and sampled on the trailing edge.
- R11: With the bit-order field set to 1, the frame is sent least significant bit first, and received bits are reassembled in the same order.
- R12: A frame of N bits sends bits N-1:0 of the written value and returns the received frame in bits N-1:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 4 removes one byte |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Serial data out, lane 0 is MOSI |
| dq_oe | output | 4 | Output enable per lane |
| dq_in | input | 4 | Serial data in, lane 1 is MISO |

## Verification
The case that is hardest to reach is the one-lane stall: the receive queue is full while a transmit byte is still waiting. It only happens when software falls behind. The stimulus writes nine bytes in a burst with a small divisor and reads nothing. It then counts chip-select pulses to confirm that exactly eight frames ran, and drains all nine bytes in order. Overflowing the transmit queue is done the same way: a two-lane burst with a slow divisor keeps the queue full, so an extra write can be shown to have been dropped by the last frame seen on the wires.

// File: rtl/spim_pkg.sv
// Shared definitions for the SPI master: register addresses, the frame
// format layout, chip-select mode codes and small helper functions.
package spim_pkg;

    localparam logic [2:0] ADR_DIV = 3'd0;
    localparam logic [2:0] ADR_FMT = 3'd1;
    localparam logic [2:0] ADR_CSM = 3'd2;
    localparam logic [2:0] ADR_TXD = 3'd3;
    localparam logic [2:0] ADR_RXD = 3'd4;

    localparam logic [1:0] CSM_AUTO = 2'd0;
    localparam logic [1:0] CSM_HOLD = 2'd1;

    typedef struct packed {
        logic [3:0] len;
        logic [1:0] rsvd;
        logic       dir_tx;
        logic       lsb;
        logic [1:0] lanes;
        logic       cpha;
        logic       cpol;
    } fmt_t;

    // Reverse the bit order of a byte.
    function automatic logic [7:0] rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    // Frame length, with 0 or values above 8 read as 8.
    function automatic logic [3:0] eff_len(input logic [3:0] code);
        return (code == 4'd0 || code > 4'd8) ? 4'd8 : code;
    endfunction

    // log2 of the number of lanes used for a lane code.
    function automatic logic [1:0] lane_lg(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
// Synchronous first-in first-out queue.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are both ignored. Read data is the head entry, shown without a
// register.
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage array: write the entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spim_clkdiv.sv
// SCK half-period timer. While run is high it counts peripheral clocks and
// gives a one-cycle tick every div+1 cycles. A restart clears the count so
// that a new frame always begins with a full half period.
module spim_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count the half period and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || !run)  cnt <= '0;
        else if (cnt == div)       cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spim_engine.sv
// Frame shift engine. It takes a byte from the transmit queue and counts
// SCK edges (two per bit group), driving and sampling the data lanes on
// the edges chosen by CPHA. It then returns the received frame. It assumes
// the format stays unchanged while a frame is in flight.
module spim_engine
    import spim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fmt_t       fmt,
    input  logic       tick,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       rx_room,
    input  logic [3:0] dq_in,
    output logic       start,
    output logic       busy,
    output logic       frame_done,
    output logic       rx_push,
    output logic [7:0] rx_data,
    output logic       sck,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe
);
    logic [7:0] sh, rs, rs_n, aligned;
    logic [4:0] k;
    logic [3:0] len, lanes_n, nsteps, nb;
    logic [1:0] lg;
    logic       need_rx, cur_need, sample, shift, last;
    logic       unused_rsvd;

    assign unused_rsvd = ^fmt.rsvd;

    assign len     = eff_len(fmt.len);
    assign lg      = lane_lg(fmt.lanes);
    assign lanes_n = 4'd1 << lg;
    assign nsteps  = (len + lanes_n - 4'd1) >> lg;
    assign nb      = nsteps << lg;
    assign need_rx = (fmt.lanes == 2'd0) || !fmt.dir_tx;

    assign start      = !busy && tx_valid && (!need_rx || rx_room);
    assign sample     = (k[0] == fmt.cpha);
    assign shift      = (k[0] != fmt.cpha) && !(fmt.cpha && k == 5'd0);
    assign last       = (k == {nsteps, 1'b0} - 5'd1);
    assign frame_done = busy && tick && last;
    assign rx_push    = frame_done && cur_need;

    // Receive shifter value after this cycle's sample, if any.
    always_comb begin
        rs_n = rs;
        if (busy && tick && sample) begin
            case (lg)
                2'd0:    rs_n = {rs[6:0], dq_in[1]};
                2'd1:    rs_n = {rs[5:0], dq_in[1:0]};
                default: rs_n = {rs[3:0], dq_in[3:0]};
            endcase
        end
    end

    // Put the received frame in the low bits, in the selected bit order.
    always_comb begin
        aligned = rs_n >> (nb - len);
        rx_data = fmt.lsb ? (rev8(aligned) >> (4'd8 - len)) : aligned;
    end

    // Lane drive: the earliest bit of each group goes on the highest lane used.
    always_comb begin
        case (lg)
            2'd0:    dq_out = {3'b000, sh[7]};
            2'd1:    dq_out = {2'b00, sh[7:6]};
            default: dq_out = sh[7:4];
        endcase
        if (fmt.lanes == 2'd0)      dq_oe = 4'b0001;
        else if (busy && fmt.dir_tx) dq_oe = (lg == 2'd1) ? 4'b0011 : 4'b1111;
        else                         dq_oe = 4'b0000;
    end

    // Frame sequencing: load, edge counting, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sck      <= 1'b0;
            sh       <= '0;
            rs       <= '0;
            k        <= '0;
            cur_need <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            sck      <= fmt.cpol;
            sh       <= fmt.lsb ? rev8(tx_data) : (tx_data << (4'd8 - len));
            rs       <= '0;
            k        <= '0;
            cur_need <= need_rx;
        end else if (busy && tick) begin
            sck <= ~sck;
            k   <= k + 5'd1;
            rs  <= rs_n;
            if (shift) sh <= sh << lanes_n;
            if (last)  busy <= 1'b0;
        end else if (!busy) begin
            sck <= fmt.cpol;
        end
    end

endmodule

// File: rtl/spim_top.sv
// SPI master top. It holds the register file, the two byte queues, the
// SCK divider, the shift engine and chip-select control. Status is read
// in bit 31 of the data registers. A read of the receive data register
// removes the byte that it returns.
module spim_top
    import spim_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int TXQ_DEPTH = 8,
    parameter int RXQ_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  dq_out,
    output logic [3:0]  dq_oe,
    input  logic [3:0]  dq_in
);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(3);
    localparam fmt_t             FMT_RST = 12'h800;

    logic [DIV_W-1:0] div_q;
    fmt_t             fmt_q;
    logic [1:0]       csm_q;
    logic             wr_tx, rd_rx, tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic             start, busy, frame_done, rx_push, tick, cs_act;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[31:12];
    assign wr_tx = bus_wr && (bus_addr == ADR_TXD);
    assign rd_rx = bus_rd && (bus_addr == ADR_RXD);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RST;
            fmt_q <= FMT_RST;
            csm_q <= CSM_AUTO;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_DIV: div_q <= bus_wdata[DIV_W-1:0];
                ADR_FMT: fmt_q <= bus_wdata[11:0];
                ADR_CSM: csm_q <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Read mux, with status in bit 31 of the data registers.
    always_comb begin
        case (bus_addr)
            ADR_DIV: bus_rdata = 32'(div_q);
            ADR_FMT: bus_rdata = 32'(fmt_q);
            ADR_CSM: bus_rdata = 32'(csm_q);
            ADR_TXD: bus_rdata = {tx_full, 31'd0};
            ADR_RXD: bus_rdata = rx_empty ? 32'h8000_0000 : {24'd0, rx_head};
            default: bus_rdata = 32'd0;
        endcase
    end

    spim_fifo #(.WIDTH(8), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_tx), .din(bus_wdata[7:0]),
        .pop(start), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.WIDTH(8), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rd_rx), .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spim_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(busy),
        .div(div_q), .tick(tick)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_q), .tick(tick),
        .tx_valid(!tx_empty), .tx_data(tx_head), .rx_room(!rx_full),
        .dq_in(dq_in), .start(start), .busy(busy), .frame_done(frame_done),
        .rx_push(rx_push), .rx_data(rx_byte), .sck(sck),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Chip-select state: assert at frame start, then release or hold by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cs_act <= 1'b0;
        else if (start)                      cs_act <= !csm_q[1];
        else if (frame_done)                 cs_act <= cs_act && (csm_q == CSM_HOLD);
        else if (!busy && csm_q != CSM_HOLD) cs_act <= 1'b0;
    end

    assign cs_n = ~cs_act;

endmodule

// File: rtl/spim_checker.sv
// Protocol checker for spim_top, attached with bind. It watches the queue
// status, the bus strobes and the serial pins, and checks the rules that
// the requirements state.
module spim_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_tx,
    input logic        rd_rx,
    input logic        tx_full,
    input logic        rx_full,
    input logic        rx_empty,
    input logic        tx_pop,
    input logic        rx_push,
    input logic        start,
    input logic        busy,
    input logic        frame_done,
    input logic [1:0]  csm,
    input logic        cpol,
    input logic [1:0]  lanes,
    input logic        dir_tx,
    input logic [31:0] rdata,
    input logic        sck,
    input logic        cs_n,
    input logic [3:0]  dq_oe
);
    // A dropped write leaves the full transmit queue full.
    assert_drop_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && wr_tx && !tx_pop |=> tx_full);

    // An empty receive queue reads as status only.
    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && rd_rx |-> rdata == 32'h8000_0000);

    // No received frame is pushed into a full queue.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // Multi-lane receive phase releases all lanes.
    assert_rx_lanes_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && lanes != 2'd0 && !dir_tx |-> dq_oe == 4'b0000);

    // Per-frame mode releases select after each frame.
    assert_auto_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && csm == 2'd0 |=> cs_n);

    // Off mode never asserts select for a new frame.
    assert_off_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && csm[1] |=> cs_n);

    // Idle SCK rests at the polarity level.
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) && $stable(cpol) |-> sck == cpol);
endmodule

bind spim_top spim_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .rd_rx(rd_rx),
    .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_pop(start), .rx_push(rx_push), .start(start), .busy(busy),
    .frame_done(frame_done), .csm(csm_q), .cpol(fmt_q.cpol),
    .lanes(fmt_q.lanes), .dir_tx(fmt_q.dir_tx), .rdata(bus_rdata),
    .sck(sck), .cs_n(cs_n), .dq_oe(dq_oe)
);

// File: tb/test_spim_top.sv
// Self-checking bench for spim_top: a loopback vector table followed by
// directed tests for lanes, queues, chip select and timing.
module test_spim_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sck, cs_n;
    logic [3:0]  dq_out, dq_oe, dq_in, drv = 4'd0;
    logic        lb = 1'b1;

    int n_chk = 0, n_err = 0;
    int ncs = 0, nfall = 0, cyc = 0, last_edge = 0, hp = 0;
    logic        sck_d = 1'b0, cs_d = 1'b1;
    logic        mcpol = 1'b0, mcpha = 1'b0;
    int          mlanes = 1;
    logic [15:0] cap = 16'd0;

    assign dq_in = lb ? {2'b00, dq_out[0], 1'b0} : drv;

    spim_top i_spim_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #10 clk = ~clk;

    // Wire monitor: lane capture on sampling edges, half period, select edges.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        sck_d <= sck;
        cs_d <= cs_n;
        if (sck !== sck_d) begin
            hp <= cyc - last_edge;
            last_edge <= cyc;
            if (sck == ~(mcpol ^ mcpha))
                cap <= (cap << mlanes) | 16'(dq_out & 4'((1 << mlanes) - 1));
        end
        if (cs_n && !cs_d) ncs <= ncs + 1;
        if (!cs_n && cs_d) nfall <= nfall + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Poll the receive register until a byte is returned.
    task automatic rx_get(output logic [31:0] d);
        d = 32'h8000_0000;
        for (int i = 0; i < 20000 && d[31]; i++) rd(3'd4, d);
    endtask

    // Back-to-back transmit writes: b0 first, then base+1 .. base+n-1.
    task automatic burst(input logic [7:0] b0, input logic [7:0] base, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bus_wr = 1'b1; bus_addr = 3'd3;
            bus_wdata = (i == 0) ? 32'(b0) : 32'(base + 8'(i));
            @(negedge clk);
        end
        bus_wr = 1'b0;
    endtask

    // Loopback table: {format[11:0], pad, tx byte, expected byte}.
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        32'h0800_A5A5,   // 8 bits, MSB first, mode 0 (R10, R12)
        32'h0810_3C3C,   // LSB first (R11)
        32'h0803_9696,   // CPOL 1, CPHA 1 (R10)
        32'h0500_F313,   // 5-bit frame keeps low bits (R12)
        32'h0302_0505,   // 3-bit frame, CPHA 1 (R12)
        32'h0611_2B2B    // 6-bit frame, LSB first, CPOL 1 (R11)
    };

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk("R8 reset cs_n", 32'(cs_n), 32'd1);
        chk("R9 reset sck", 32'(sck), 32'd0);
        chk("R3 reset dq_oe", 32'(dq_oe), 32'd1);
        rd(3'd3, d); chk("R1 reset tx status", d, 32'd0);
        rd(3'd4, d); chk("R2 empty rx read", d, 32'h8000_0000);

        // Full-duplex loopback table (R3 pushes one byte per frame).
        lb = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, 32'(VEC[v][27:16]));
            wr(3'd3, 32'(VEC[v][15:8]));
            rx_get(d);
            chk("R3 R12 loopback byte", d, 32'(VEC[v][7:0]));
        end
        rd(3'd4, d); chk("R2 one byte per frame", d, 32'h8000_0000);

        // R9: half period is divisor+1 clocks; idle level follows CPOL.
        wr(3'd0, 32'd4);
        wr(3'd1, 32'h800);
        wr(3'd3, 32'h11);
        rx_get(d);
        chk("R9 half period", 32'(hp), 32'd5);
        wr(3'd1, 32'h801);
        repeat (2) @(negedge clk);
        chk("R9 idle at CPOL 1", 32'(sck), 32'd1);

        // R10: capture on the trailing edge with CPHA 1, leading with CPHA 0.
        wr(3'd0, 32'd2);
        mcpol = 1'b0; mcpha = 1'b1; mlanes = 1;
        wr(3'd1, 32'h802);
        wr(3'd3, 32'hC3);
        rx_get(d);
        chk("R10 CPHA1 wire bits", 32'(cap[7:0]), 32'hC3);
        mcpha = 1'b0;
        wr(3'd1, 32'h800);
        wr(3'd3, 32'h5A);
        rx_get(d);
        chk("R10 CPHA0 wire bits", 32'(cap[7:0]), 32'h5A);

        // R4, R1, R6: dual-lane transmit burst with a slow divisor.
        wr(3'd0, 32'd20);
        mlanes = 2;
        wr(3'd1, 32'h824);
        base = ncs;
        burst(8'hB4, 8'h00, 9);
        rd(3'd3, d); chk("R1 tx full status", d, 32'h8000_0000);
        wr(3'd3, 32'hEE);
        @(posedge cs_n); @(negedge clk);
        chk("R4 dual lanes MSB first", 32'(cap[7:0]), 32'hB4);
        @(negedge cs_n); @(negedge clk);
        chk("R4 dual dq_oe", 32'(dq_oe), 32'h3);
        wait (ncs == base + 9);
        repeat (400) @(negedge clk);
        chk("R6 one cs pulse per frame", 32'(ncs - base), 32'd9);
        chk("R1 write while full dropped", 32'(cap[7:0]), 32'h08);
        rd(3'd4, d); chk("R4 nothing received in tx phase", d, 32'h8000_0000);

        // R11: dual lane, LSB first.
        wr(3'd1, 32'h834);
        wr(3'd3, 32'hB4);
        @(posedge cs_n); @(negedge clk);
        chk("R11 dual LSB first", 32'(cap[7:0]), 32'h2D);

        // Quad transmit.
        mlanes = 4;
        wr(3'd0, 32'd3);
        wr(3'd1, 32'h82C);
        wr(3'd3, 32'h9E);
        @(negedge cs_n); @(negedge clk);
        chk("R4 quad dq_oe", 32'(dq_oe), 32'hF);
        @(posedge cs_n); @(negedge clk);
        chk("R4 quad lanes", 32'(cap[7:0]), 32'h9E);

        // R5: quad receive phase.
        lb = 1'b0; drv = 4'hA;
        wr(3'd1, 32'h808);
        wr(3'd3, 32'h00);
        @(negedge cs_n); @(negedge clk);
        chk("R5 lanes released", 32'(dq_oe), 32'h0);
        rx_get(d);
        chk("R5 quad receive byte", d, 32'hAA);

        // R3: receive queue full stalls the ninth frame.
        lb = 1'b1;
        wr(3'd0, 32'd1);
        wr(3'd1, 32'h800);
        base = ncs;
        burst(8'h31, 8'h31, 9);
        repeat (600) @(negedge clk);
        chk("R3 stall at full rx queue", 32'(ncs - base), 32'd8);
        for (int i = 0; i < 9; i++) begin
            rx_get(d);
            chk("R3 R2 drained in order", d, 32'(8'h31 + 8'(i)));
        end

        // R7: hold mode keeps select low; leaving hold mid-frame waits.
        wr(3'd0, 32'd3);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'h44);
        rx_get(d);
        repeat (5) @(negedge clk);
        chk("R7 hold after frame", 32'(cs_n), 32'd0);
        wr(3'd2, 32'd0);
        repeat (2) @(negedge clk);
        chk("R7 release when idle", 32'(cs_n), 32'd1);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'h45);
        @(negedge cs_n);
        repeat (3) @(negedge clk);
        wr(3'd2, 32'd0);
        chk("R7 held through frame in flight", 32'(cs_n), 32'd0);
        rx_get(d);
        chk("R7 released after frame", 32'(cs_n), 32'd1);

        // R8: off mode never asserts select.
        base = nfall;
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h46);
        rx_get(d);
        chk("R8 off mode data", d, 32'h46);
        chk("R8 no select in off mode", 32'(nfall - base), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule